// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register file of a colour LCD controller. It sits on a simple 32-bit peripheral bus that is addressed in words. The bus presents a valid strobe, a write flag, a 10-bit word address and write data, and read data comes back one cycle after a read. The block holds:

- four panel timing words,
- two frame base addresses (upper and lower panel),
- a control word,
- an interrupt mask, a raw interrupt status and a write-one-to-clear register,
- a 128-word colour palette window,
- eight read-only identification bytes.

From the stored words it decodes the active line width in pixels, the panel height in lines, the pixel-depth code, the colour-order and endianness flags, and a display-enable flag. These outputs go to the pixel fetch and timing logic, which are not part of this block.

A `VERSION` parameter selects the layout. Version 0 is the base layout. Versions 1 and 2 exchange the word offsets of the control and mask registers. Version 2 also reports a different identification sequence.

Downstream logic raises interrupt events on `evt_set`. Each event bit latches into the raw status. The `irq` output is high while any latched bit is also enabled in the mask. Every bus write produces a one-cycle `invalidate` pulse, which tells the display side to redraw.

Top module: `lcdc_regif`

## Requirements
- R1: When `rst_n` is sampled low, every register and every palette word becomes 0. After reset the read data, `irq`, `invalidate` and all control-derived flags are 0, `pix_per_line` is 16 and `lines_per_panel` is 1.
- R2: Word offsets 0 to 3 hold timing words 0 to 3, offset 4 holds the upper frame base and offset 5 the lower frame base, all 32 bits wide. Offsets 11 and 12 read back the upper and lower base.
- R3: With `VERSION` 0, word 6 is the interrupt mask and word 7 is the control word. With any other `VERSION`, the two offsets are exchanged for reads and for writes. The mask keeps the low `IRQ_W` bits of the written value and reads back zero-extended.
- R4: Word offsets 0x3F8 to 0x3FF each read one identification byte in bits 7:0, indexed by the word address bits 2:0. `VERSION` 0 and 1 return 10 11 04 00 0D F0 05 B1 in index order. `VERSION` 2 returns 11 11 24 00 0D F0 05 B1.
- R5: `pix_per_line` equals ((timing0 & 0xFC) + 4) * 4.
- R6: `lines_per_panel` equals (timing1 & 0x3FF) + 1.
- R7: `disp_en` is 1 only when control bits 0 and 11 are both 1. `depth_code` is control bits 3:1. `bgr_swap` is control bit 8, `be_bytes` is bit 9 and `be_pixels` is bit 10.
- R8: A 1 on `evt_set` bit i sets raw status bit i at the next clock. Word 8 reads the raw status and word 9 reads raw AND mask. `irq` is 1 exactly when raw AND mask is non-zero.
- R9: A write to word 10 clears each raw status bit whose written bit is 1 and leaves the others. If an event sets the same bit in the same cycle, the bit ends up set.
- R10: Word offsets 0x080 to 0x0FF form a 128-word palette. A write there stores all 32 bits at index (word − 0x080), and a read returns the stored word.
- R11: Reads of undefined offsets (13 to 0x07F, 0x100 to 0x3F7) and of word 10 return 0. Writes to those offsets and to the read-only words 8, 9, 11, 12 and 0x3F8 to 0x3FF change no register.
- R12: `invalidate` is 1 for exactly the one cycle after each accepted write, at any offset, and is 0 otherwise.
- R13: `bus_rdata` carries the value read in the cycle after a read request and is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| evt_set | input | IRQ_W | Interrupt events that set raw status bits |
| irq | output | 1 | Masked interrupt request |
| invalidate | output | 1 | One-cycle pulse after any write |
| disp_en | output | 1 | Display active (enable and power both set) |
| pix_per_line | output | 11 | Decoded pixels per line |
| lines_per_panel | output | 11 | Decoded lines per panel |
| depth_code | output | 3 | Pixel-depth code |
| bgr_swap | output | 1 | Colour component order flag |
| be_bytes | output | 1 | Big-endian byte order flag |
| be_pixels | output | 1 | Big-endian pixel order flag |
| frame_base_up | output | 32 | Upper panel frame base |
| frame_base_lo | output | 32 | Lower panel frame base |

## Verification
The embedded assertions watch the following on every cycle:
- the invalidate pulse following each write and only a write,
- read data returning to zero when no read was issued,
- latching of interrupt events,
- the effect of a clear write,
- the enable flag never rising without both control bits.

Other behaviour depends on stored contents and on the version layout: the swapped control and mask offsets, the identification sequence, palette storage at both ends of the window, the width and height arithmetic at field extremes, and undefined writes leaving state intact. These are shown only by the bench scenarios. There, a behavioural model runs both a base and an extended instance side by side.

// File: rtl/lcdc_pkg.sv
// Package: shared constants, register-select type and identification bytes
// for the LCD controller register interface.
// Assumes a 32-bit data bus with 1024 word addresses (4 KB window).
package lcdc_pkg;

    localparam int BUS_AW    = 10;
    localparam int BUS_DW    = 32;
    localparam int GEOM_W    = 11;
    localparam int PAL_WORDS = 128;
    localparam int PAL_IW    = $clog2(PAL_WORDS);

    typedef enum logic [3:0] {
        SEL_NONE, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3,
        SEL_UPB,  SEL_LPB,  SEL_MASK, SEL_CTRL, SEL_RAW,
        SEL_MSKD, SEL_CLR,  SEL_UPC,  SEL_LPC,  SEL_PAL, SEL_ID
    } lcdc_sel_e;

    // Identification byte for a layout version and byte index.
    function automatic logic [7:0] lcdc_id_byte(input int version, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = (version == 2) ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = (version == 2) ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
// Module: lcdc_addr_decode
// Maps a bus word address onto a register select, a palette index and an
// identification index. VERSION 0 keeps mask at word 6 and control at word 7;
// other versions exchange them. Purely combinational.
module lcdc_addr_decode
    import lcdc_pkg::*;
#(
    parameter int VERSION = 0
) (
    input  logic [BUS_AW-1:0] word_addr,
    output lcdc_sel_e         sel,
    output logic [PAL_IW-1:0] pal_idx,
    output logic [2:0]        id_idx
);

    lcdc_sel_e sel_w6;
    lcdc_sel_e sel_w7;

    // Choose the version-dependent meaning of words 6 and 7.
    generate
        if (VERSION == 0) begin : g_base_layout
            assign sel_w6 = SEL_MASK;
            assign sel_w7 = SEL_CTRL;
        end else begin : g_swapped_layout
            assign sel_w6 = SEL_CTRL;
            assign sel_w7 = SEL_MASK;
        end
    endgenerate

    assign pal_idx = word_addr[PAL_IW-1:0];
    assign id_idx  = word_addr[2:0];

    // Decode the window region, then the individual register words.
    always_comb begin
        sel = SEL_NONE;
        if (word_addr[9:7] == 3'b001) begin
            sel = SEL_PAL;
        end else if (word_addr[9:3] == 7'h7F) begin
            sel = SEL_ID;
        end else if (word_addr[9:4] == 6'd0) begin
            case (word_addr[3:0])
                4'd0:    sel = SEL_TIM0;
                4'd1:    sel = SEL_TIM1;
                4'd2:    sel = SEL_TIM2;
                4'd3:    sel = SEL_TIM3;
                4'd4:    sel = SEL_UPB;
                4'd5:    sel = SEL_LPB;
                4'd6:    sel = sel_w6;
                4'd7:    sel = sel_w7;
                4'd8:    sel = SEL_RAW;
                4'd9:    sel = SEL_MSKD;
                4'd10:   sel = SEL_CLR;
                4'd11:   sel = SEL_UPC;
                4'd12:   sel = SEL_LPC;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcdc_geometry.sv
// Module: lcdc_geometry
// Turns the stored timing and control fields into panel width, height,
// depth and mode flags for the display pipeline. Combinational; assumes the
// caller passes the raw register slices.
module lcdc_geometry
    import lcdc_pkg::*;
(
    input  logic [5:0]        ppl_field,
    input  logic [9:0]        lpp_field,
    input  logic              en_bit,
    input  logic              pwr_bit,
    input  logic [2:0]        depth_bits,
    input  logic              bgr_bit,
    input  logic              bebo_bit,
    input  logic              bepo_bit,
    output logic [GEOM_W-1:0] pix_per_line,
    output logic [GEOM_W-1:0] lines_per_panel,
    output logic              disp_en,
    output logic [2:0]        depth_code,
    output logic              bgr_swap,
    output logic              be_bytes,
    output logic              be_pixels
);

    logic [6:0] ppl_groups;

    // Width: (field + 1) groups of 16 pixels.
    always_comb begin
        ppl_groups   = {1'b0, ppl_field} + 7'd1;
        pix_per_line = {ppl_groups, 4'b0000};
    end

    // Height: line field plus one.
    assign lines_per_panel = {1'b0, lpp_field} + 11'd1;

    // Display runs only when both enable and power are on.
    assign disp_en    = en_bit & pwr_bit;
    assign depth_code = depth_bits;
    assign bgr_swap   = bgr_bit;
    assign be_bytes   = bebo_bit;
    assign be_pixels  = bepo_bit;

endmodule

// File: rtl/lcdc_palette.sv
// Module: lcdc_palette
// Palette storage of WORDS 32-bit entries with one write port and one
// combinational read port. Cleared by synchronous active-low reset.
module lcdc_palette #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [WORDS];

    // Store one palette word per write; clear all words on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/lcdc_regif.sv
// Module: lcdc_regif (top)
// Register file of the LCD controller: timing, frame bases, control,
// interrupt mask/status/clear, palette and identification bytes on a
// valid/write bus with one-cycle registered read data.
// Assumes one request per cycle and word addressing.
module lcdc_regif
    import lcdc_pkg::*;
#(
    parameter int VERSION = 0,
    parameter int IRQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  evt_set,
    output logic              irq,
    output logic              invalidate,
    output logic              disp_en,
    output logic [GEOM_W-1:0] pix_per_line,
    output logic [GEOM_W-1:0] lines_per_panel,
    output logic [2:0]        depth_code,
    output logic              bgr_swap,
    output logic              be_bytes,
    output logic              be_pixels,
    output logic [BUS_DW-1:0] frame_base_up,
    output logic [BUS_DW-1:0] frame_base_lo
);

    localparam int NUM_TIM = 4;

    lcdc_sel_e         sel;
    logic [PAL_IW-1:0] pal_idx;
    logic [2:0]        id_idx;
    logic [BUS_DW-1:0] pal_rd;
    logic [BUS_DW-1:0] rd_mux;
    logic [BUS_DW-1:0] tim_q [NUM_TIM];
    logic [BUS_DW-1:0] upb_q, lpb_q, ctrl_q;
    logic [IRQ_W-1:0]  mask_q, raw_q, clr_bits;
    logic              wr_stb, rd_stb;

    assign wr_stb = bus_valid & bus_write;
    assign rd_stb = bus_valid & ~bus_write;

    lcdc_addr_decode #(.VERSION(VERSION)) u_decode (
        .word_addr (bus_addr),
        .sel       (sel),
        .pal_idx   (pal_idx),
        .id_idx    (id_idx)
    );

    lcdc_palette #(.WORDS(PAL_WORDS), .DW(BUS_DW)) u_palette (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb && (sel == SEL_PAL)),
        .wr_idx  (pal_idx),
        .wr_data (bus_wdata),
        .rd_idx  (pal_idx),
        .rd_data (pal_rd)
    );

    lcdc_geometry u_geometry (
        .ppl_field       (tim_q[0][7:2]),
        .lpp_field       (tim_q[1][9:0]),
        .en_bit          (ctrl_q[0]),
        .pwr_bit         (ctrl_q[11]),
        .depth_bits      (ctrl_q[3:1]),
        .bgr_bit         (ctrl_q[8]),
        .bebo_bit        (ctrl_q[9]),
        .bepo_bit        (ctrl_q[10]),
        .pix_per_line    (pix_per_line),
        .lines_per_panel (lines_per_panel),
        .disp_en         (disp_en),
        .depth_code      (depth_code),
        .bgr_swap        (bgr_swap),
        .be_bytes        (be_bytes),
        .be_pixels       (be_pixels)
    );

    // Bits removed from the raw status by a clear-register write.
    assign clr_bits = (wr_stb && (sel == SEL_CLR)) ? bus_wdata[IRQ_W-1:0] : '0;

    // Register writes and raw status update (events win over clears).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIM; i++) begin
                tim_q[i] <= '0;
            end
            upb_q  <= '0;
            lpb_q  <= '0;
            ctrl_q <= '0;
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_stb) begin
                case (sel)
                    SEL_TIM0: tim_q[0] <= bus_wdata;
                    SEL_TIM1: tim_q[1] <= bus_wdata;
                    SEL_TIM2: tim_q[2] <= bus_wdata;
                    SEL_TIM3: tim_q[3] <= bus_wdata;
                    SEL_UPB:  upb_q    <= bus_wdata;
                    SEL_LPB:  lpb_q    <= bus_wdata;
                    SEL_MASK: mask_q   <= bus_wdata[IRQ_W-1:0];
                    SEL_CTRL: ctrl_q   <= bus_wdata;
                    default:  ;
                endcase
            end
            raw_q <= (raw_q & ~clr_bits) | evt_set;
        end
    end

    // Read multiplexer over all readable words.
    always_comb begin
        case (sel)
            SEL_TIM0:         rd_mux = tim_q[0];
            SEL_TIM1:         rd_mux = tim_q[1];
            SEL_TIM2:         rd_mux = tim_q[2];
            SEL_TIM3:         rd_mux = tim_q[3];
            SEL_UPB, SEL_UPC: rd_mux = upb_q;
            SEL_LPB, SEL_LPC: rd_mux = lpb_q;
            SEL_MASK:         rd_mux = BUS_DW'(mask_q);
            SEL_CTRL:         rd_mux = ctrl_q;
            SEL_RAW:          rd_mux = BUS_DW'(raw_q);
            SEL_MSKD:         rd_mux = BUS_DW'(raw_q & mask_q);
            SEL_PAL:          rd_mux = pal_rd;
            SEL_ID:           rd_mux = BUS_DW'(lcdc_id_byte(VERSION, id_idx));
            default:          rd_mux = '0;
        endcase
    end

    // Registered read data and write-triggered invalidate pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            invalidate <= 1'b0;
        end else begin
            bus_rdata  <= rd_stb ? rd_mux : '0;
            invalidate <= wr_stb;
        end
    end

    assign irq           = |(raw_q & mask_q);
    assign frame_base_up = upb_q;
    assign frame_base_lo = lpb_q;

    // R12: a write is followed by an invalidate pulse.
    a_r12_inval_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> invalidate);

    // R12: no write, no invalidate in the next cycle.
    a_r12_inval_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> !invalidate);

    // R13: read data is zero when no read was requested.
    a_r13_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> (bus_rdata == '0));

    // R8: an event bit is latched into the raw status.
    a_r8_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

    // R9: a clear without concurrent events removes every written bit.
    a_r9_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (sel == SEL_CLR) && (evt_set == '0))
        |=> ((raw_q & $past(bus_wdata[IRQ_W-1:0])) == '0));

    // R7: the display never runs without both enable and power bits.
    a_r7_enable_bits: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (ctrl_q[0] && ctrl_q[11]));

endmodule

// File: tb/lcdc_regif_tb.sv
`timescale 1ns/1ps
// Bench: drives a base-layout and an extended-layout instance with the same
// bus traffic and compares both, every clock, against a behavioural model.
module lcdc_regif_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bv = 1'b0, bw = 1'b0;
    logic [9:0]  ba = '0;
    logic [31:0] bd = '0;
    logic [3:0]  evt = '0;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit in_rst  = 1;

    always #10 clk = ~clk;

    logic [31:0] d_rd [2];
    logic        d_irq [2], d_inv [2];
    logic [5:0]  d_flags [2];
    logic [10:0] d_ppl [2], d_lpp [2];
    logic [31:0] d_up [2], d_lo [2];

    logic        f0_en, f0_bgr, f0_bb, f0_bp, f1_en, f1_bgr, f1_bb, f1_bp;
    logic [2:0]  f0_dep, f1_dep;

    lcdc_regif #(.VERSION(0), .IRQ_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
        .bus_wdata(bd), .bus_rdata(d_rd[0]), .evt_set(evt), .irq(d_irq[0]),
        .invalidate(d_inv[0]), .disp_en(f0_en), .pix_per_line(d_ppl[0]),
        .lines_per_panel(d_lpp[0]), .depth_code(f0_dep), .bgr_swap(f0_bgr),
        .be_bytes(f0_bb), .be_pixels(f0_bp), .frame_base_up(d_up[0]),
        .frame_base_lo(d_lo[0]));

    lcdc_regif #(.VERSION(2), .IRQ_W(4)) u_dut_ext (
        .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
        .bus_wdata(bd), .bus_rdata(d_rd[1]), .evt_set(evt), .irq(d_irq[1]),
        .invalidate(d_inv[1]), .disp_en(f1_en), .pix_per_line(d_ppl[1]),
        .lines_per_panel(d_lpp[1]), .depth_code(f1_dep), .bgr_swap(f1_bgr),
        .be_bytes(f1_bb), .be_pixels(f1_bp), .frame_base_up(d_up[1]),
        .frame_base_lo(d_lo[1]));

    assign d_flags[0] = {f0_en, f0_bgr, f0_bb, f0_bp, f0_dep[1:0]} ^ {5'd0, f0_dep[2]};
    assign d_flags[1] = {f1_en, f1_bgr, f1_bb, f1_bp, f1_dep[1:0]} ^ {5'd0, f1_dep[2]};

    // Behavioural model state, one copy per layout (0 base, 1 extended).
    logic [31:0] m_tim [2][4];
    logic [31:0] m_up [2], m_lo [2], m_ctrl [2], m_mask [2], m_raw [2];
    logic [31:0] m_pal [2][128];
    logic [31:0] m_rd [2];
    logic        m_inv [2];
    string       m_tag [2];

    byte id_base [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    byte id_ext  [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic logic [31:0] mread(input int v, input int w, output string tag);
        tag = "R2";
        if (w >= 'h80 && w <= 'hFF) begin tag = "R10"; return m_pal[v][w - 'h80]; end
        if (w >= 'h3F8) begin
            tag = "R4";
            return v ? {24'd0, id_ext[w - 'h3F8]} : {24'd0, id_base[w - 'h3F8]};
        end
        case (w)
            0, 1, 2, 3: return m_tim[v][w];
            4, 11:      return m_up[v];
            5, 12:      return m_lo[v];
            6: begin tag = "R3"; return v ? m_ctrl[v] : m_mask[v]; end
            7: begin tag = "R3"; return v ? m_mask[v] : m_ctrl[v]; end
            8: begin tag = "R8"; return m_raw[v]; end
            9: begin tag = "R8 R9"; return m_raw[v] & m_mask[v]; end
            default: begin tag = "R11"; return 32'd0; end
        endcase
    endfunction

    // Model update at each rising edge, from the pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            in_rst = 1;
            for (int v = 0; v < 2; v++) begin
                for (int i = 0; i < 4; i++) m_tim[v][i] = 0;
                for (int i = 0; i < 128; i++) m_pal[v][i] = 0;
                m_up[v] = 0; m_lo[v] = 0; m_ctrl[v] = 0; m_mask[v] = 0; m_raw[v] = 0;
                m_rd[v] = 0; m_inv[v] = 0; m_tag[v] = "R1";
            end
        end else begin
            in_rst = 0;
            for (int v = 0; v < 2; v++) begin
                logic [31:0] clr;
                string t;
                clr = 0;
                if (bv && !bw) begin
                    m_rd[v] = mread(v, int'(ba), t);
                    m_tag[v] = t;
                end else begin
                    m_rd[v] = 0;
                    m_tag[v] = "R13";
                end
                m_inv[v] = bv && bw;
                if (bv && bw) begin
                    if (ba >= 'h80 && ba <= 'hFF) m_pal[v][ba - 'h80] = bd;
                    else case (int'(ba))
                        0, 1, 2, 3: m_tim[v][ba[1:0]] = bd;
                        4: m_up[v] = bd;
                        5: m_lo[v] = bd;
                        6: if (v != 0) m_ctrl[v] = bd; else m_mask[v] = bd & 32'hF;
                        7: if (v != 0) m_mask[v] = bd & 32'hF; else m_ctrl[v] = bd;
                        10: clr = bd;
                        default: ;
                    endcase
                end
                m_raw[v] = (m_raw[v] & ~clr & 32'hF) | {28'd0, evt};
            end
        end
        started = 1;
    end

    task automatic chk(input string tag, input int v, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (inst %0d): actual=%h expected=%h at %0t", tag, v, act, exp, $time);
        end
    endtask

    // Compare both instances with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            for (int v = 0; v < 2; v++) begin
                logic [31:0] ppl, lpp, c;
                logic [5:0]  fl;
                c   = m_ctrl[v];
                ppl = ((m_tim[v][0] & 32'hFC) + 4) * 4;
                lpp = (m_tim[v][1] & 32'h3FF) + 1;
                fl  = {c[0] & c[11], c[8], c[9], c[10], c[2:1]} ^ {5'd0, c[3]};
                chk(in_rst ? "R1" : m_tag[v], v, d_rd[v], m_rd[v]);
                chk(in_rst ? "R1" : "R5", v, 32'(d_ppl[v]), ppl);
                chk(in_rst ? "R1" : "R6", v, 32'(d_lpp[v]), lpp);
                chk(in_rst ? "R1" : "R7", v, 32'(d_flags[v]), 32'(fl));
                chk(in_rst ? "R1" : "R8", v, 32'(d_irq[v]), 32'(|(m_raw[v] & m_mask[v])));
                chk(in_rst ? "R1" : "R12", v, 32'(d_inv[v]), 32'(m_inv[v]));
                chk(in_rst ? "R1" : "R2", v, d_up[v], m_up[v]);
                chk(in_rst ? "R1" : "R2", v, d_lo[v], m_lo[v]);
            end
        end
    end

    task automatic drive(input logic v, input logic w, input int a, input logic [31:0] d, input logic [3:0] e);
        @(negedge clk);
        #1;
        bv = v; bw = w; ba = a[9:0]; bd = d; evt = e;
    endtask

    task automatic wr(input int a, input logic [31:0] d); drive(1, 1, a, d, 4'd0); endtask
    task automatic rd(input int a); drive(1, 0, a, 32'd0, 4'd0); endtask
    task automatic idle(); drive(0, 0, 0, 32'd0, 4'd0); endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 R2 R3 R4: reset readback of every defined word and the ID bytes.
        for (int i = 0; i <= 12; i++) rd(i);
        for (int i = 'h3F8; i <= 'h3FF; i++) rd(i);
        // R5 R6: width and height at field extremes.
        wr(0, 32'h0000_00FC); rd(0);
        wr(0, 32'hFFFF_FFFF); rd(0);
        wr(0, 32'h0000_0053);
        wr(1, 32'h0000_03FF); rd(1);
        wr(1, 32'hFFFF_F123);
        wr(2, 32'hA5A5_5A5A); wr(3, 32'h1234_5678); rd(2); rd(3);
        wr(4, 32'h8000_1000); wr(5, 32'h8004_0000); rd(4); rd(5); rd(11); rd(12);
        // R3 R7: layout swap and enable/power combinations.
        wr(6, 32'h0000_0001); rd(6); rd(7);
        wr(7, 32'h0000_0001); rd(6); rd(7);
        wr(6, 32'h0000_0800); wr(7, 32'h0000_0800);
        wr(6, 32'h0000_0801); wr(7, 32'h0000_0E0E);
        wr(7, 32'h0000_0FFF); wr(6, 32'h0000_0FFF); rd(6); rd(7);
        wr(6, 32'h0000_0000); wr(7, 32'h0000_0000);
        // R8 R9: events, mask, masked status and clear.
        drive(0, 0, 0, 32'd0, 4'b0101); idle(); rd(8); rd(9);
        wr(6, 32'h0000_0004); wr(7, 32'h0000_0004); rd(9);
        wr(10, 32'h0000_0004); rd(8); rd(9);
        drive(1, 1, 10, 32'h0000_000F, 4'b0001); rd(8);
        drive(1, 1, 10, 32'h0000_000F, 4'b0000); rd(8); rd(10);
        // R10: palette ends and middle.
        wr('h080, 32'hDEAD_BEEF); wr('h0FF, 32'h0123_4567); wr('h0C0, 32'hFFFF_0000);
        rd('h080); rd('h0FF); rd('h0C0); rd('h081);
        // R11: undefined and read-only writes leave state unchanged.
        wr(13, 32'hFFFF_FFFF); wr('h07F, 32'hFFFF_FFFF); wr('h100, 32'hFFFF_FFFF);
        wr('h3F7, 32'hFFFF_FFFF); wr('h3F8, 32'hFFFF_FFFF); wr(8, 32'hF); wr(9, 32'hF);
        wr(11, 32'h0); wr(12, 32'h0);
        rd(13); rd('h07F); rd('h100); rd('h3F7); rd('h3F8);
        for (int i = 0; i <= 12; i++) rd(i);
        // R13: back-to-back reads, then idle cycles return zero.
        rd('h3FF); rd(0); idle(); idle();
        repeat (3) idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule